// File: doc/BRIEF.md
# Two-Channel Converter Start Trigger Controller

This block decides, for each of two 12-bit digital-to-analog output channels, the exact cycle in which a conversion starts. Software loads codes and settings through a simple single-cycle register write port. Each channel then starts in one of several ways. It can start on a write of its own data. It can start on a rising edge of one of twelve event inputs. It can start on a shared refresh timer, or on a per-channel sensor-controller strobe. Some modes combine a data write with an event or with the refresh timer. A combined data word loads both channels in one write. It also counts as a data-write trigger for every channel whose mode accepts writes.

For each start, the block gives a one-cycle start strobe and the 12-bit code latched at that start. It also sets a per-channel conversion-done flag. Flags can be set or cleared by software and are gated by per-channel enables onto one interrupt line. Channels are switched on and off through a write-only command word, and their state is visible on a status output. The refresh timer runs from a converter clock made by dividing the system clock by the prescaler value plus one. The timer fires once every 8, 16, 32 or 64 converter-clock ticks.

Top module: `dac_trig_ctrl`

## Requirements
- R1: After reset both channels are disabled, all start strobes, done flags and the interrupt are 0, and both latched codes are 0.
- R2: A write to address 1 enables channel c when bit 2c is 1 and disables it when bit 2c+1 is 1. If both are 1 the channel ends disabled. chan_en_o[c] shows the enabled state in the cycle after the write.
- R3: While a channel is disabled, none of its trigger sources produce a start strobe.
- R4: In mode 0, a write to the channel's data register (address 4 for channel 0, 5 for channel 1; bits 11:0) pulses start_o[c] for one cycle in the cycle after the write. code_o then holds the written value until the next start.
- R5: A write to address 6 loads channel 0 from bits 11:0 and channel 1 from bits 27:16. It starts only those channels whose mode accepts data writes (0, 3 or 4), and the other channels keep the new data for later triggers.
- R6: In mode 1, the channel starts once on a rising edge of event line evt_i[s], where s is the event-select field (bits 7:4 of the channel control word at address 2 or 3; the mode is bits 2:0). A held level gives only one start, and select values 12 to 15 never start.
- R7: In mode 2, the channel starts on the refresh timer only, and data writes do not start it. Address 0 holds the prescaler in bits 6:0 and the refresh code in bits 9:8. Starts are spaced (prescaler+1) x (8 << code) cycles apart.
- R8: Mode 3 starts on a data write or a selected event edge, and mode 4 starts on a data write or a refresh tick.
- R9: In mode 5, the channel starts in the cycle after sens_i[c] is high.
- R10: Mode codes 6 and 7 produce no starts from any source.
- R11: A start sets done_o[c]. Writing 1 to bit c at address 7 sets the flag and at address 8 clears it, and a set wins over a clear. irq_o is the OR of done flags whose enable bit (address 9, bit c) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 4 | Register word address |
| wr_data_i | input | 32 | Register write data |
| evt_i | input | 12 | Event lines, synchronous to clk |
| sens_i | input | 2 | Per-channel sensor-controller start request |
| start_o | output | 2 | Per-channel one-cycle conversion start strobe |
| code_o | output | 24 | Latched codes, channel c in bits 12c+11:12c |
| chan_en_o | output | 2 | Per-channel enabled status |
| done_o | output | 2 | Per-channel conversion-done flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume a few things about the inputs. Event and sensor lines are already synchronous to clk. A write lasts one cycle and carries a single address. The mode and select fields only change through that write port, so a mode change takes effect at the same edge as any trigger it gates. The stimulus drives every input at the falling edge and writes registers one at a time. Refresh spacing is measured only after several periods at a fixed setting. The write-versus-refresh checks wait until just after a refresh in a very slow setting, so a timer tick cannot coincide with the write under test.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int DW    = 12;  // channel code width
  localparam int NEV   = 12;  // event lines
  localparam int ESW   = 4;   // event select width
  localparam int MW    = 3;   // trigger mode width
  localparam int PSW   = 7;   // prescaler width
  localparam int PRW   = 2;   // refresh period code width
  localparam int RBASE = 3;   // log2 of shortest refresh period
  localparam int RCW   = RBASE + (1 << PRW) - 1;
  localparam int AW    = 4;   // register address width
  localparam int CSLOT = 16;  // combined word slot per channel

  localparam logic [AW-1:0] A_GLOB  = 4'd0;
  localparam logic [AW-1:0] A_CMD   = 4'd1;
  localparam logic [AW-1:0] A_CTL0  = 4'd2;
  localparam logic [AW-1:0] A_DATA0 = 4'd4;
  localparam logic [AW-1:0] A_COMB  = 4'd6;
  localparam logic [AW-1:0] A_FSET  = 4'd7;
  localparam logic [AW-1:0] A_FCLR  = 4'd8;
  localparam logic [AW-1:0] A_IEN   = 4'd9;

  localparam logic [MW-1:0] M_WRITE   = 3'd0;
  localparam logic [MW-1:0] M_EVENT   = 3'd1;
  localparam logic [MW-1:0] M_REFRESH = 3'd2;
  localparam logic [MW-1:0] M_WR_EV   = 3'd3;
  localparam logic [MW-1:0] M_WR_RF   = 3'd4;
  localparam logic [MW-1:0] M_SENSOR  = 3'd5;
endpackage

// File: rtl/dtc_regs.sv
module dtc_regs
  import dtc_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [31:0]             wr_data,
  input  logic [NCH-1:0]          start_i,
  output logic [PSW-1:0]          presc_o,
  output logic [PRW-1:0]          period_o,
  output logic [NCH-1:0][MW-1:0]  mode_o,
  output logic [NCH-1:0][ESW-1:0] evsel_o,
  output logic [NCH-1:0][DW-1:0]  data_nxt_o,
  output logic [NCH-1:0]          data_wr_o,
  output logic [NCH-1:0]          en_o,
  output logic [NCH-1:0]          done_o,
  output logic [NCH-1:0]          ie_o
);
  logic [PSW-1:0] presc_q, presc_d;
  logic [PRW-1:0] period_q, period_d;
  logic           glob_we;

  always_comb begin
    glob_we  = wr_en && (wr_addr == A_GLOB);
    presc_d  = glob_we ? wr_data[PSW-1:0] : presc_q;
    period_d = glob_we ? wr_data[8 +: PRW] : period_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q  <= '0;
      period_q <= '0;
    end else begin
      presc_q  <= presc_d;
      period_q <= period_d;
    end
  end

  assign presc_o  = presc_q;
  assign period_o = period_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0]  data_q, data_d;
    logic [MW-1:0]  mode_q, mode_d;
    logic [ESW-1:0] sel_q, sel_d;
    logic           en_q, en_d, done_q, done_d, ie_q, ie_d;
    logic           own_we, comb_we, ctl_we, cmd_we;

    always_comb begin
      own_we  = wr_en && (wr_addr == A_DATA0 + AW'(c));
      comb_we = wr_en && (wr_addr == A_COMB);
      ctl_we  = wr_en && (wr_addr == A_CTL0 + AW'(c));
      cmd_we  = wr_en && (wr_addr == A_CMD);
      data_d  = own_we  ? wr_data[DW-1:0] :
                comb_we ? wr_data[c*CSLOT +: DW] : data_q;
      mode_d  = ctl_we ? wr_data[0 +: MW]  : mode_q;
      sel_d   = ctl_we ? wr_data[4 +: ESW] : sel_q;
      en_d    = en_q;
      if (cmd_we) begin
        en_d = (en_q | wr_data[2*c]) & ~wr_data[2*c+1];
      end
      done_d  = start_i[c]
              | (wr_en && (wr_addr == A_FSET) && wr_data[c])
              | (done_q & ~(wr_en && (wr_addr == A_FCLR) && wr_data[c]));
      ie_d    = (wr_en && (wr_addr == A_IEN)) ? wr_data[c] : ie_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        mode_q <= '0;
        sel_q  <= '0;
        en_q   <= 1'b0;
        done_q <= 1'b0;
        ie_q   <= 1'b0;
      end else begin
        data_q <= data_d;
        mode_q <= mode_d;
        sel_q  <= sel_d;
        en_q   <= en_d;
        done_q <= done_d;
        ie_q   <= ie_d;
      end
    end

    assign data_nxt_o[c] = data_d;
    assign data_wr_o[c]  = own_we | comb_we;
    assign mode_o[c]     = mode_q;
    assign evsel_o[c]    = sel_q;
    assign en_o[c]       = en_q;
    assign done_o[c]     = done_q;
    assign ie_o[c]       = ie_q;

    // R2
    cmd_both_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == A_CMD) && wr_data[2*c] && wr_data[2*c+1]) |=> !en_q);

    // R11
    done_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i[c] |=> done_q);
  end
endmodule

// File: rtl/dtc_refresh.sv
module dtc_refresh
  import dtc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PSW-1:0] presc_i,
  input  logic [PRW-1:0] period_i,
  output logic           tick_o
);
  logic [PSW-1:0] pc_q, pc_d;
  logic [RCW-1:0] rc_q, rc_d, lim;
  logic           conv_tick;

  always_comb begin
    conv_tick = (pc_q >= presc_i);
    pc_d      = conv_tick ? '0 : pc_q + 1'b1;
    lim       = (RCW'(1) << (RBASE + int'(period_i))) - 1'b1;
    tick_o    = conv_tick && (rc_q >= lim);
    rc_d      = rc_q;
    if (conv_tick) begin
      rc_d = (rc_q >= lim) ? '0 : rc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      rc_q <= '0;
    end else begin
      pc_q <= pc_d;
      rc_q <= rc_d;
    end
  end

  // R7
  refresh_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/dtc_chan.sv
module dtc_chan
  import dtc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic [MW-1:0]  mode_i,
  input  logic [ESW-1:0] evsel_i,
  input  logic [NEV-1:0] ev_rise_i,
  input  logic [DW-1:0]  data_nxt_i,
  input  logic           data_wr_i,
  input  logic           refresh_i,
  input  logic           sensor_i,
  output logic           start_o,
  output logic [DW-1:0]  code_o
);
  logic          ev_hit, trig, start_d, start_q;
  logic [DW-1:0] code_d, code_q;

  always_comb begin
    ev_hit = 1'b0;
    for (int i = 0; i < NEV; i++) begin
      if (evsel_i == ESW'(i)) ev_hit = ev_hit | ev_rise_i[i];
    end
    case (mode_i)
      M_WRITE:   trig = data_wr_i;
      M_EVENT:   trig = ev_hit;
      M_REFRESH: trig = refresh_i;
      M_WR_EV:   trig = data_wr_i | ev_hit;
      M_WR_RF:   trig = data_wr_i | refresh_i;
      M_SENSOR:  trig = sensor_i;
      default:   trig = 1'b0;
    endcase
    start_d = en_i & trig;
    code_d  = start_d ? data_nxt_i : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      code_q  <= '0;
    end else begin
      start_q <= start_d;
      code_q  <= code_d;
    end
  end

  assign start_o = start_q;
  assign code_o  = code_q;

  // R3
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !start_q);

  // R10
  resv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i > M_SENSOR) |=> !start_q);

  // R4
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |-> start_q);
endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
  import dtc_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [NEV-1:0]    evt_i,
  input  logic [NCH-1:0]    sens_i,
  output logic [NCH-1:0]    start_o,
  output logic [NCH*DW-1:0] code_o,
  output logic [NCH-1:0]    chan_en_o,
  output logic [NCH-1:0]    done_o,
  output logic              irq_o
);
  logic [NEV-1:0]          evt_q, ev_rise;
  logic [PSW-1:0]          presc;
  logic [PRW-1:0]          period;
  logic [NCH-1:0][MW-1:0]  mode;
  logic [NCH-1:0][ESW-1:0] evsel;
  logic [NCH-1:0][DW-1:0]  data_nxt;
  logic [NCH-1:0]          data_wr, en, done, ie, start;
  logic                    refresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_i;
  end

  assign ev_rise = evt_i & ~evt_q;

  dtc_regs #(.NCH(NCH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en_i),
    .wr_addr    (wr_addr_i),
    .wr_data    (wr_data_i),
    .start_i    (start),
    .presc_o    (presc),
    .period_o   (period),
    .mode_o     (mode),
    .evsel_o    (evsel),
    .data_nxt_o (data_nxt),
    .data_wr_o  (data_wr),
    .en_o       (en),
    .done_o     (done),
    .ie_o       (ie)
  );

  dtc_refresh u_refresh (
    .clk      (clk),
    .rst_n    (rst_n),
    .presc_i  (presc),
    .period_i (period),
    .tick_o   (refresh)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [DW-1:0] code_c;
    dtc_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en[c]),
      .mode_i     (mode[c]),
      .evsel_i    (evsel[c]),
      .ev_rise_i  (ev_rise),
      .data_nxt_i (data_nxt[c]),
      .data_wr_i  (data_wr[c]),
      .refresh_i  (refresh),
      .sensor_i   (sens_i[c]),
      .start_o    (start[c]),
      .code_o     (code_c)
    );
    assign code_o[c*DW +: DW] = code_c;
  end

  assign start_o   = start;
  assign chan_en_o = en;
  assign done_o    = done;
  assign irq_o     = |(done & ie);
endmodule

// File: tb/sim_dac_trig_ctrl.sv
module sim_dac_trig_ctrl;
  localparam int NCH = 2;
  localparam int DW  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [3:0]        wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [11:0]       evt = '0;
  logic [NCH-1:0]    sens = '0;
  logic [NCH-1:0]    start, chan_en, done;
  logic [NCH*DW-1:0] code;
  logic              irq;

  always #5 clk = ~clk;

  dac_trig_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .evt_i     (evt),
    .sens_i    (sens),
    .start_o   (start),
    .code_o    (code),
    .chan_en_o (chan_en),
    .done_o    (done),
    .irq_o     (irq)
  );

  int       n_tests = 0;
  int       n_fail  = 0;
  int       q_ch[$];
  int       q_code[$];
  string    q_req[$];
  bit       sb_on = 1'b1;
  string    cur_req = "R3";
  int       cyc = 0;
  int       last_t[NCH];
  int       intv[NCH];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int ch, input int cd, input string req);
    q_ch.push_back(ch);
    q_code.push_back(cd);
    q_req.push_back(req);
  endtask

  // monitor: pops expected starts and compares
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (start[c]) begin
          if (sb_on) begin
            if (q_ch.size() == 0) begin
              chk(1'b0, cur_req, "unexpected start on channel", c, -1);
            end else begin
              int    ech;
              int    ecd;
              string erq;
              ech = q_ch.pop_front();
              ecd = q_code.pop_front();
              erq = q_req.pop_front();
              chk(ech == c, erq, "start channel", c, ech);
              chk(int'(code[c*DW +: DW]) == ecd, erq, "start code",
                  int'(code[c*DW +: DW]), ecd);
            end
          end else begin
            intv[c]   = cyc - last_t[c];
            last_t[c] = cyc;
          end
        end
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a[3:0];
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // write, then verify every expected start arrived in the following cycle
  task automatic wr_exp(input int a, input int d, input string req);
    wr(a, d);
    #1;
    chk(q_ch.size() == 0, req, "starts missing one cycle after write", q_ch.size(), 0);
  endtask

  task automatic pulse_evt(input int line);
    @(negedge clk);
    evt[line] = 1'b1;
    @(negedge clk);
    evt[line] = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (3) @(negedge clk);
    #1;
    chk(q_ch.size() == 0, req, "pending expected starts", q_ch.size(), 0);
    q_ch.delete();
    q_code.delete();
    q_req.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int old;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(start == 0, "R1", "start_o", start, 0);
    chk(chan_en == 0, "R1", "chan_en_o", chan_en, 0);
    chk(done == 0 && irq == 0, "R1", "done/irq", {done, irq}, 0);
    chk(code == 0, "R1", "code_o", code, 0);

    // R3 disabled channel ignores data write
    cur_req = "R3";
    wr(4, 'h123);
    drain("R3");
    chk(chan_en == 0, "R3", "chan_en_o", chan_en, 0);

    // R2 enable both
    wr(1, 'h5);
    chk(chan_en == 2'b11, "R2", "chan_en_o after enable", chan_en, 3);

    // R4 software writes
    cur_req = "R4";
    push(0, 'hABC, "R4");
    wr_exp(4, 'hABC, "R4");
    push(1, 'h5A5, "R4");
    wr_exp(5, 'h5A5, "R4");
    repeat (2) @(negedge clk);
    chk(code == 24'h5A5ABC, "R4", "code_o held", code, 24'h5A5ABC);

    // R11 done flags and interrupt
    chk(done == 2'b11, "R11", "done after starts", done, 3);
    chk(irq == 1'b0, "R11", "irq with enables off", irq, 0);
    wr(9, 'h1);
    chk(irq == 1'b1, "R11", "irq with enable 0", irq, 1);
    wr(8, 'h3);
    chk(done == 0 && irq == 0, "R11", "done/irq after clear", {done, irq}, 0);
    wr(7, 'h2);
    chk(done == 2'b10 && irq == 0, "R11", "set flag 1", {done, irq}, 4);
    wr(7, 'h1);
    chk(irq == 1'b1, "R11", "set flag 0 irq", irq, 1);
    wr(8, 'h3);

    // R5 combined word
    cur_req = "R5";
    push(0, 'h111, "R5");
    push(1, 'h222, "R5");
    wr_exp(6, 'h0222_0111, "R5");
    wr(3, 'h51);               // ch1: event mode, line 5
    push(0, 'h444, "R5");
    wr_exp(6, 'h0333_0444, "R5");
    drain("R5");

    // R6 event edge, held level, bad select
    cur_req = "R6";
    push(1, 'h333, "R6");
    @(negedge clk);
    evt[5] = 1'b1;
    @(negedge clk);
    #1;
    chk(q_ch.size() == 0, "R6", "event start missing", q_ch.size(), 0);
    repeat (4) @(negedge clk);
    evt[5] = 1'b0;
    pulse_evt(4);
    drain("R6");
    wr(3, 'hC1);               // select 12: never fires
    @(negedge clk);
    evt = '1;
    repeat (2) @(negedge clk);
    evt = '0;
    drain("R6");

    // R9 sensor trigger
    cur_req = "R9";
    wr(2, 'h05);
    push(0, 'h444, "R9");
    @(negedge clk);
    sens[0] = 1'b1;
    @(negedge clk);
    sens[0] = 1'b0;
    #1;
    chk(q_ch.size() == 0, "R9", "sensor start missing", q_ch.size(), 0);
    @(negedge clk);
    sens[1] = 1'b1;            // ch1 is in event mode
    @(negedge clk);
    sens[1] = 1'b0;
    drain("R9");

    // R10 reserved modes
    cur_req = "R10";
    wr(2, 'h06);
    wr(4, 'h777);
    @(negedge clk);
    sens[0] = 1'b1;
    @(negedge clk);
    sens[0] = 1'b0;
    drain("R10");
    wr(2, 'h07);
    pulse_evt(0);
    wr(4, 'h777);
    drain("R10");

    // R8 write-or-event mode
    cur_req = "R8";
    wr(2, 'h23);
    push(0, 'h7A1, "R8");
    wr_exp(4, 'h7A1, "R8");
    push(0, 'h7A1, "R8");
    pulse_evt(2);
    drain("R8");

    // R2 enable and disable together, R3 ignored triggers
    wr(1, 'h3);
    chk(chan_en == 2'b10, "R2", "chan_en_o after en+dis", chan_en, 2);
    cur_req = "R3";
    wr(4, 'h0AA);
    pulse_evt(2);
    drain("R3");
    wr(1, 'h1);
    chk(chan_en == 2'b11, "R2", "chan_en_o re-enabled", chan_en, 3);

    // R7 refresh timing (ch0 refresh-only, ch1 write-or-refresh)
    sb_on = 1'b0;
    wr(2, 'h02);
    wr(3, 'h04);
    wr(0, 'h000);
    repeat (40) @(negedge clk);
    chk(intv[0] == 8, "R7", "refresh interval code 0", intv[0], 8);
    chk(intv[1] == 8, "R8", "mode 4 refresh interval", intv[1], 8);
    wr(0, 'h200);
    repeat (110) @(negedge clk);
    chk(intv[0] == 32, "R7", "refresh interval code 2", intv[0], 32);
    wr(0, 'h001);
    repeat (60) @(negedge clk);
    chk(intv[0] == 16, "R7", "refresh interval prescaler 1", intv[0], 16);

    // slow refresh: check writes right after a tick
    wr(0, 'h37F);
    for (int i = 0; i < 20000 && !start[0]; i++) @(negedge clk);
    chk(start[0] == 1'b1, "R7", "slow refresh observed", start[0], 1);
    old = int'(code[DW-1:0]);
    wr(4, 'h1E1);
    chk(start[0] == 1'b0 && int'(code[DW-1:0]) == old, "R7",
        "write ignored in refresh-only mode", int'(code[DW-1:0]), old);
    wr(2, 'h04);
    wr(4, 'h5C3);
    chk(start[0] == 1'b1 && code[DW-1:0] == 12'h5C3, "R8",
        "write starts in mode 4", int'(code[DW-1:0]), 'h5C3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule